// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides, one request at a time, whether a downstream access seen on the primary side of a PCI-to-PCI bridge falls inside one of the bridge's forwarding windows and should be claimed for the secondary side. It takes the raw contents of the bridge's I/O, memory and prefetchable-memory base and limit registers and rebuilds each window's full-width lower and upper bounds. The bounds include the optional upper-word extension and the fixed all-ones fill on the limit's low bits. It then compares the request address against the window that matches the request's kind.

The command-register enables gate the windows. The I/O enable gates the I/O window, and the memory enable gates both memory windows. A window whose limit lies below its base is empty. When the bridge-control VGA enable is set, the legacy display ranges are claimed as well, whatever the command enables say. The verdict appears on registered outputs one cycle after the valid strobe, as a hit flag with a one-hot tag that names the window that matched.

Top module: `bwd_decoder`

## Requirements
- R1: The I/O window lower bound is ioBaseReg[7:4] placed at address bits 15:12. When ioBaseReg[0] is 1, ioBaseHi supplies bits 31:16; otherwise those bits are zero. The upper bound is built the same way from ioLimitReg (its own bit 0 selects ioLimitHi), with bits 11:0 forced to ones. An I/O request matches only when its address bits 63:32 are zero.
- R2: The memory window lower bound is memBaseReg[15:4] at address bits 31:20. The upper bound is memLimitReg[15:4] at bits 31:20 with bits 19:0 forced to ones. Bits 3:0 of both registers have no effect.
- R3: The prefetchable window bounds are built from prefBaseReg[15:4] and prefLimitReg[15:4] at bits 31:20, with the limit's bits 19:0 forced to ones. Bit 0 of each register, when 1, takes bits 63:32 from prefBaseHi or prefLimitHi respectively; otherwise those bits are zero.
- R4: A window covers addresses from its lower through its upper bound inclusive. A window whose upper bound is below its lower bound claims nothing.
- R5: ioEnable gates the I/O window. memEnable gates both the memory and prefetchable windows. A window whose enable is 0 claims nothing.
- R6: When vgaEnable is 1, an I/O request is claimed at 0x3B0 through 0x3BB and at 0x3C0 through 0x3DF (address bits 63:32 zero). A memory or prefetchable request is claimed at 0xA0000 through 0xBFFFF. These claims happen regardless of ioEnable and memEnable. When vgaEnable is 0, these ranges get no special treatment.
- R7: reqKind encodes 0 = I/O, 1 = memory, 2 = prefetchable memory, 3 = reserved. A request is compared only against the window of its own kind, and a reserved request is never claimed.
- R8: The outputs are registered. In the cycle after a cycle with reqValid high, claimValid is 1. claimWindow is one-hot: bit 0 = I/O, bit 1 = memory, bit 2 = prefetchable, bit 3 = VGA, or zero on a miss. claimHit is 1 exactly when claimWindow is nonzero. After a cycle with reqValid low, all three outputs are zero.
- R9: When a VGA range and the request's own window both match, the VGA tag is reported.
- R10: While rstN is low, claimValid, claimHit and claimWindow are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioBaseReg | input | 8 | I/O base byte: range in 7:4, 32-bit flag in bit 0 |
| ioLimitReg | input | 8 | I/O limit byte: range in 7:4, 32-bit flag in bit 0 |
| ioBaseHi | input | 16 | I/O base address bits 31:16 |
| ioLimitHi | input | 16 | I/O limit address bits 31:16 |
| memBaseReg | input | 16 | Memory base word, range in 15:4 |
| memLimitReg | input | 16 | Memory limit word, range in 15:4 |
| prefBaseReg | input | 16 | Prefetchable base word: range in 15:4, 64-bit flag in bit 0 |
| prefLimitReg | input | 16 | Prefetchable limit word: range in 15:4, 64-bit flag in bit 0 |
| prefBaseHi | input | 32 | Prefetchable base address bits 63:32 |
| prefLimitHi | input | 32 | Prefetchable limit address bits 63:32 |
| ioEnable | input | 1 | Command I/O space enable |
| memEnable | input | 1 | Command memory space enable |
| vgaEnable | input | 1 | Bridge-control VGA forwarding enable |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 2 | Request kind (R7 encoding) |
| reqAddr | input | ADDR_W | Request address |
| claimValid | output | 1 | Verdict present for the previous cycle's request |
| claimHit | output | 1 | Request is claimed |
| claimWindow | output | 4 | One-hot matching window |

## Verification
A full sweep of every I/O base and limit nibble pair is probed at each 4 KiB page's first and last byte. This separates off-by-one bound errors, a missing low-bit fill and inverted-window handling. A memory sweep over base and limit fields puts junk in the low nibbles and probes each 1 MiB edge, which exposes mis-shifted fields and any dependence on reserved bits. A prefetchable sweep crosses the wide flag with several upper-word values, so the upper-word extension is told apart from a plain 32-bit window. Dense scans across the display ranges, run with the command enables both on and off, separate VGA claims from window claims and confirm which one wins.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W    = 64;
  localparam int IO_SPAN_W = 32;
  localparam int WIN_N     = 4;

  localparam int WIN_IO   = 0;
  localparam int WIN_MEM  = 1;
  localparam int WIN_PREF = 2;
  localparam int WIN_VGA  = 3;

  typedef enum logic [1:0] {
    KIND_IO   = 2'd0,
    KIND_MEM  = 2'd1,
    KIND_PREF = 2'd2,
    KIND_RSVD = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic capture;
    logic ioSel;
    logic memSel;
    logic prefSel;
  } ctrlStrobe_t;

  localparam logic [ADDR_W-1:0] VGA_IO_LO_FIRST = 64'h3B0;
  localparam logic [ADDR_W-1:0] VGA_IO_LO_LAST  = 64'h3BB;
  localparam logic [ADDR_W-1:0] VGA_IO_HI_FIRST = 64'h3C0;
  localparam logic [ADDR_W-1:0] VGA_IO_HI_LAST  = 64'h3DF;
  localparam logic [ADDR_W-1:0] VGA_MEM_FIRST   = 64'hA0000;
  localparam logic [ADDR_W-1:0] VGA_MEM_LAST    = 64'hBFFFF;
endpackage

// File: rtl/bwd_window.sv
module bwd_window #(
  parameter int LOW_BITS = 12,
  parameter int FIELD_W  = 4,
  parameter int UPPER_W  = 16,
  parameter int ADDR_W   = 64
) (
  input  logic [FIELD_W-1:0] baseField,
  input  logic [FIELD_W-1:0] limitField,
  input  logic [UPPER_W-1:0] baseUpper,
  input  logic [UPPER_W-1:0] limitUpper,
  input  logic               baseWide,
  input  logic               limitWide,
  input  logic               enable,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               addrOk,
  output logic               hit
);
  localparam int UPPER_LSB = LOW_BITS + FIELD_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] limitAddr;
  logic              windowOpen;

  // Bounds: field sits above the granularity bits, optional upper word above it.
  always_comb begin
    baseAddr = '0;
    baseAddr[LOW_BITS +: FIELD_W] = baseField;
    if (baseWide) baseAddr[UPPER_LSB +: UPPER_W] = baseUpper;

    limitAddr = '0;
    limitAddr[LOW_BITS-1:0] = '1;
    limitAddr[LOW_BITS +: FIELD_W] = limitField;
    if (limitWide) limitAddr[UPPER_LSB +: UPPER_W] = limitUpper;
  end

  assign windowOpen = enable && (limitAddr >= baseAddr);
  assign hit = windowOpen && addrOk && (addr >= baseAddr) && (addr <= limitAddr);
endmodule

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  output ctrlStrobe_t strobe
);
  reqKind_e kind;

  assign kind = reqKind_e'(reqKind);

  always_comb begin
    strobe = '0;
    strobe.capture = reqValid;
    if (reqValid) begin
      unique case (kind)
        KIND_IO:   strobe.ioSel   = 1'b1;
        KIND_MEM:  strobe.memSel  = 1'b1;
        KIND_PREF: strobe.prefSel = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/bwd_datapath.sv
module bwd_datapath
  import bwd_pkg::*;
#(
  parameter int ADDR_W    = bwd_pkg::ADDR_W,
  parameter int IO_SPAN_W = bwd_pkg::IO_SPAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [7:0]        ioBaseReg,
  input  logic [7:0]        ioLimitReg,
  input  logic [15:0]       ioBaseHi,
  input  logic [15:0]       ioLimitHi,
  input  logic [15:0]       memBaseReg,
  input  logic [15:0]       memLimitReg,
  input  logic [15:0]       prefBaseReg,
  input  logic [15:0]       prefLimitReg,
  input  logic [31:0]       prefBaseHi,
  input  logic [31:0]       prefLimitHi,
  input  logic              ioEnable,
  input  logic              memEnable,
  input  logic              vgaEnable,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              claimValid,
  output logic              claimHit,
  output logic [WIN_N-1:0]  claimWindow
);
  localparam int IO_GRAN   = 12;
  localparam int MEM_GRAN  = 20;
  localparam int IO_FLD_W  = 4;
  localparam int MEM_FLD_W = 12;

  logic ioAddrOk;
  logic [WIN_N-1:0] winHit;
  logic [WIN_N-1:0] nextWindow;
  logic vgaIoHit, vgaMemHit;
  logic unusedCfgBits;

  assign ioAddrOk = (reqAddr[ADDR_W-1:IO_SPAN_W] == '0);
  assign unusedCfgBits = ^{ioBaseReg[3:1], ioLimitReg[3:1], memBaseReg[3:0],
                           memLimitReg[3:0], prefBaseReg[3:1], prefLimitReg[3:1]};

  bwd_window #(.LOW_BITS(IO_GRAN), .FIELD_W(IO_FLD_W), .UPPER_W(16), .ADDR_W(ADDR_W)) ioWin_i (
    .baseField(ioBaseReg[7:4]), .limitField(ioLimitReg[7:4]),
    .baseUpper(ioBaseHi), .limitUpper(ioLimitHi),
    .baseWide(ioBaseReg[0]), .limitWide(ioLimitReg[0]),
    .enable(ioEnable), .addr(reqAddr), .addrOk(ioAddrOk), .hit(winHit[WIN_IO])
  );

  bwd_window #(.LOW_BITS(MEM_GRAN), .FIELD_W(MEM_FLD_W), .UPPER_W(16), .ADDR_W(ADDR_W)) memWin_i (
    .baseField(memBaseReg[15:4]), .limitField(memLimitReg[15:4]),
    .baseUpper(16'h0), .limitUpper(16'h0),
    .baseWide(1'b0), .limitWide(1'b0),
    .enable(memEnable), .addr(reqAddr), .addrOk(1'b1), .hit(winHit[WIN_MEM])
  );

  bwd_window #(.LOW_BITS(MEM_GRAN), .FIELD_W(MEM_FLD_W), .UPPER_W(32), .ADDR_W(ADDR_W)) prefWin_i (
    .baseField(prefBaseReg[15:4]), .limitField(prefLimitReg[15:4]),
    .baseUpper(prefBaseHi), .limitUpper(prefLimitHi),
    .baseWide(prefBaseReg[0]), .limitWide(prefLimitReg[0]),
    .enable(memEnable), .addr(reqAddr), .addrOk(1'b1), .hit(winHit[WIN_PREF])
  );

  // Legacy display ranges, independent of the command enables.
  assign vgaIoHit = ioAddrOk &&
                    (((reqAddr >= VGA_IO_LO_FIRST) && (reqAddr <= VGA_IO_LO_LAST)) ||
                     ((reqAddr >= VGA_IO_HI_FIRST) && (reqAddr <= VGA_IO_HI_LAST)));
  assign vgaMemHit = (reqAddr >= VGA_MEM_FIRST) && (reqAddr <= VGA_MEM_LAST);
  assign winHit[WIN_VGA] = vgaEnable &&
                           ((strobe.ioSel && vgaIoHit) ||
                            ((strobe.memSel || strobe.prefSel) && vgaMemHit));

  always_comb begin
    nextWindow = '0;
    if (winHit[WIN_VGA])                       nextWindow[WIN_VGA]  = 1'b1;
    else if (strobe.ioSel && winHit[WIN_IO])   nextWindow[WIN_IO]   = 1'b1;
    else if (strobe.memSel && winHit[WIN_MEM]) nextWindow[WIN_MEM]  = 1'b1;
    else if (strobe.prefSel && winHit[WIN_PREF]) nextWindow[WIN_PREF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      claimValid  <= 1'b0;
      claimHit    <= 1'b0;
      claimWindow <= '0;
    end else if (strobe.capture) begin
      claimValid  <= 1'b1;
      claimHit    <= |nextWindow;
      claimWindow <= nextWindow;
    end else begin
      claimValid  <= 1'b0;
      claimHit    <= 1'b0;
      claimWindow <= '0;
    end
  end
endmodule

// File: rtl/bwd_decoder.sv
module bwd_decoder
  import bwd_pkg::*;
#(
  parameter int ADDR_W = bwd_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        ioBaseReg,
  input  logic [7:0]        ioLimitReg,
  input  logic [15:0]       ioBaseHi,
  input  logic [15:0]       ioLimitHi,
  input  logic [15:0]       memBaseReg,
  input  logic [15:0]       memLimitReg,
  input  logic [15:0]       prefBaseReg,
  input  logic [15:0]       prefLimitReg,
  input  logic [31:0]       prefBaseHi,
  input  logic [31:0]       prefLimitHi,
  input  logic              ioEnable,
  input  logic              memEnable,
  input  logic              vgaEnable,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              claimValid,
  output logic              claimHit,
  output logic [3:0]        claimWindow
);
  ctrlStrobe_t strobe;

  bwd_ctrl ctrl_i (
    .reqValid(reqValid), .reqKind(reqKind), .strobe(strobe)
  );

  bwd_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ioBaseReg(ioBaseReg), .ioLimitReg(ioLimitReg),
    .ioBaseHi(ioBaseHi), .ioLimitHi(ioLimitHi),
    .memBaseReg(memBaseReg), .memLimitReg(memLimitReg),
    .prefBaseReg(prefBaseReg), .prefLimitReg(prefLimitReg),
    .prefBaseHi(prefBaseHi), .prefLimitHi(prefLimitHi),
    .ioEnable(ioEnable), .memEnable(memEnable), .vgaEnable(vgaEnable),
    .reqAddr(reqAddr),
    .claimValid(claimValid), .claimHit(claimHit), .claimWindow(claimWindow)
  );
endmodule

// File: rtl/bwd_decoder_checker.sv
module bwd_decoder_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqKind,
  input logic       ioEnable,
  input logic       memEnable,
  input logic       vgaEnable,
  input logic       claimValid,
  input logic       claimHit,
  input logic [3:0] claimWindow
);
  // R8: verdict follows the strobe by one cycle
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> claimValid);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!claimValid && !claimHit && claimWindow == 4'b0));
  assert_window_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(claimWindow));
  assert_hit_has_tag_R8: assert property (@(posedge clk) disable iff (!rstN)
    claimHit |-> ($countones(claimWindow) == 1));
  // R7: reserved kind never claims
  assert_reserved_miss_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd3) |=> !claimHit);
  // R5: disabled windows claim nothing without VGA
  assert_io_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0 && !ioEnable && !vgaEnable) |=> !claimHit);
  assert_mem_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind != 2'd0 && !memEnable && !vgaEnable) |=> !claimHit);
  // R6: VGA tag needs VGA enable
  assert_vga_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !vgaEnable) |=> !claimWindow[3]);
  // R10: reset clears the verdict
  assert_reset_clear_R10: assert property (@(posedge clk)
    !rstN |=> (!claimValid && !claimHit));
endmodule

bind bwd_decoder bwd_decoder_checker chk_i (.*);

// File: tb/bwd_decoder_tb.sv
module bwd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  ioBaseReg, ioLimitReg;
  logic [15:0] ioBaseHi, ioLimitHi;
  logic [15:0] memBaseReg, memLimitReg, prefBaseReg, prefLimitReg;
  logic [31:0] prefBaseHi, prefLimitHi;
  logic        ioEnable, memEnable, vgaEnable;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic [63:0] reqAddr;
  logic        claimValid, claimHit;
  logic [3:0]  claimWindow;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwd_decoder dut_i (
    .clk(clk), .rstN(rstN),
    .ioBaseReg(ioBaseReg), .ioLimitReg(ioLimitReg),
    .ioBaseHi(ioBaseHi), .ioLimitHi(ioLimitHi),
    .memBaseReg(memBaseReg), .memLimitReg(memLimitReg),
    .prefBaseReg(prefBaseReg), .prefLimitReg(prefLimitReg),
    .prefBaseHi(prefBaseHi), .prefLimitHi(prefLimitHi),
    .ioEnable(ioEnable), .memEnable(memEnable), .vgaEnable(vgaEnable),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .claimValid(claimValid), .claimHit(claimHit), .claimWindow(claimWindow)
  );

  // Arithmetic reference model of the requirements.
  function automatic logic [3:0] model(input logic [1:0] k, input logic [63:0] a);
    logic [63:0] lo, hi;
    logic inWin;
    logic ioOk;
    ioOk = (a < 64'h1_0000_0000);
    if (vgaEnable) begin
      if (k == 2'd0 && ioOk && ((a >= 64'h3B0 && a <= 64'h3BB) || (a >= 64'h3C0 && a <= 64'h3DF)))
        return 4'b1000;
      if ((k == 2'd1 || k == 2'd2) && a >= 64'hA0000 && a <= 64'hBFFFF)
        return 4'b1000;
    end
    case (k)
      2'd0: begin
        lo = 64'(ioBaseReg[7:4]) * 64'h1000 + (ioBaseReg[0] ? 64'(ioBaseHi) * 64'h10000 : 64'h0);
        hi = 64'(ioLimitReg[7:4]) * 64'h1000 + 64'hFFF + (ioLimitReg[0] ? 64'(ioLimitHi) * 64'h10000 : 64'h0);
        inWin = ioEnable && ioOk && hi >= lo && a >= lo && a <= hi;
        return inWin ? 4'b0001 : 4'b0000;
      end
      2'd1: begin
        lo = 64'(memBaseReg >> 4) * 64'h100000;
        hi = 64'(memLimitReg >> 4) * 64'h100000 + 64'hFFFFF;
        inWin = memEnable && hi >= lo && a >= lo && a <= hi;
        return inWin ? 4'b0010 : 4'b0000;
      end
      2'd2: begin
        lo = 64'(prefBaseReg >> 4) * 64'h100000 + (prefBaseReg[0] ? 64'(prefBaseHi) * 64'h1_0000_0000 : 64'h0);
        hi = 64'(prefLimitReg >> 4) * 64'h100000 + 64'hFFFFF + (prefLimitReg[0] ? 64'(prefLimitHi) * 64'h1_0000_0000 : 64'h0);
        inWin = memEnable && hi >= lo && a >= lo && a <= hi;
        return inWin ? 4'b0100 : 4'b0000;
      end
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got valid/hit/win=%b expected %b", tag, got, exp);
    end
  endtask

  // Called at a negative edge; returns at the next negative edge after checking.
  task automatic issue(input logic [1:0] k, input logic [63:0] a, input string tag);
    logic [3:0] e;
    reqValid = 1'b1;
    reqKind  = k;
    reqAddr  = a;
    e = model(k, a);
    @(negedge clk);
    check(tag, {claimValid, claimHit, claimWindow}, {1'b1, |e, e});
  endtask

  task automatic idle(input string tag);
    reqValid = 1'b0;
    @(negedge clk);
    check(tag, {claimValid, claimHit, claimWindow}, 6'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0;
    ioBaseReg = 8'h0; ioLimitReg = 8'h0; ioBaseHi = 16'h0; ioLimitHi = 16'h0;
    memBaseReg = 16'h0; memLimitReg = 16'h0; prefBaseReg = 16'h0; prefLimitReg = 16'h0;
    prefBaseHi = 32'h0; prefLimitHi = 32'h0;
    ioEnable = 1'b1; memEnable = 1'b1; vgaEnable = 1'b0;
    reqValid = 1'b1; reqKind = 2'd0; reqAddr = 64'h0;
    repeat (3) @(negedge clk);
    // R10: reset holds outputs low even with a strobe present
    check("R10", {claimValid, claimHit, claimWindow}, 6'b0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R1/R4: every I/O base/limit nibble pair, page edges
    for (int b = 0; b < 16; b++) begin
      for (int l = 0; l < 16; l++) begin
        ioBaseReg = {b[3:0], 4'h0};
        ioLimitReg = {l[3:0], 4'h0};
        for (int k = 0; k < 16; k++) begin
          issue(2'd0, 64'(k) * 64'h1000, (l < b) ? "R4" : "R1");
          issue(2'd0, 64'(k) * 64'h1000 + 64'hFFF, (l < b) ? "R4" : "R1");
        end
      end
    end

    // R1: 32-bit I/O extension
    ioBaseReg = 8'h21; ioLimitReg = 8'h31; ioBaseHi = 16'h0012; ioLimitHi = 16'h0012;
    issue(2'd0, 64'h0012_2000, "R1");
    issue(2'd0, 64'h0012_3FFF, "R1");
    issue(2'd0, 64'h0012_4000, "R1");
    issue(2'd0, 64'h0012_1FFF, "R1");
    issue(2'd0, 64'h0000_2000, "R1");
    ioBaseReg = 8'h20; ioLimitReg = 8'h30;
    issue(2'd0, 64'h0012_2000, "R1");
    issue(2'd0, 64'h0000_3FFF, "R1");
    issue(2'd0, 64'h1_0000_2000, "R1");

    // R2/R4: memory window sweep with junk low nibbles
    for (int b = 0; b < 8; b++) begin
      for (int l = 0; l < 8; l++) begin
        memBaseReg = {b[3:0], 8'h00, 4'h5};
        memLimitReg = {l[3:0], 8'h00, 4'hA};
        for (int k = 0; k < 8; k++) begin
          issue(2'd1, 64'(k) * 64'h1000_0000, (l < b) ? "R4" : "R2");
          issue(2'd1, 64'(k) * 64'h1000_0000 + 64'hFFFFF, (l < b) ? "R4" : "R2");
          issue(2'd1, 64'(k) * 64'h1000_0000 + 64'h100000, (l < b) ? "R4" : "R2");
          issue(2'd1, 64'(k) * 64'h1000_0000 + 64'hFFF_FFFF, (l < b) ? "R4" : "R2");
        end
      end
    end

    // R3: prefetchable window with and without upper extension
    for (int fb = 0; fb < 2; fb++) begin
      for (int bh = 0; bh < 3; bh++) begin
        for (int lh = 0; lh < 3; lh++) begin
          prefBaseReg = {4'h4, 8'h00, 3'b000, fb[0]};
          prefLimitReg = {4'h8, 8'h00, 3'b000, fb[0]};
          prefBaseHi = 32'(bh);
          prefLimitHi = 32'(lh);
          for (int h = 0; h < 3; h++) begin
            issue(2'd2, 64'(h) * 64'h1_0000_0000 + 64'h4000_0000, "R3");
            issue(2'd2, 64'(h) * 64'h1_0000_0000 + 64'h8FFF_FFFF, "R3");
            issue(2'd2, 64'(h) * 64'h1_0000_0000 + 64'h9000_0000, "R3");
            issue(2'd2, 64'(h) * 64'h1_0000_0000 + 64'h3FFF_FFFF, "R3");
          end
        end
      end
    end

    // R7: kind selects the window; reserved never claims
    ioBaseReg = 8'h00; ioLimitReg = 8'hF0; ioBaseHi = 16'h0; ioLimitHi = 16'h0;
    memBaseReg = 16'h0000; memLimitReg = 16'h0FF0;
    prefBaseReg = 16'h1000; prefLimitReg = 16'h1FF0; prefBaseHi = 32'h0; prefLimitHi = 32'h0;
    issue(2'd3, 64'h100, "R7");
    issue(2'd3, 64'h0100_0000, "R7");
    issue(2'd1, 64'h1000_0000, "R7");
    issue(2'd2, 64'h0100_0000, "R7");
    issue(2'd2, 64'h1000_0000, "R7");
    issue(2'd0, 64'h0100_0000, "R7");

    // R5: command enables
    ioEnable = 1'b0;
    issue(2'd0, 64'h100, "R5");
    issue(2'd1, 64'h0100_0000, "R5");
    ioEnable = 1'b1; memEnable = 1'b0;
    issue(2'd0, 64'h100, "R5");
    issue(2'd1, 64'h0100_0000, "R5");
    issue(2'd2, 64'h1000_0000, "R5");

    // R6: VGA ranges with command enables off
    ioEnable = 1'b0; memEnable = 1'b0; vgaEnable = 1'b1;
    for (int a = 'h380; a < 'h400; a++) issue(2'd0, 64'(a), "R6");
    issue(2'd0, 64'h1_0000_03B0, "R6");
    for (int a = 'h9F; a < 'hC1; a++) begin
      issue(2'd1, 64'(a) * 64'h1000, "R6");
      issue(2'd2, 64'(a) * 64'h1000 + 64'hFFF, "R6");
    end
    issue(2'd3, 64'hA0000, "R6");
    vgaEnable = 1'b0;
    issue(2'd0, 64'h3C0, "R6");
    issue(2'd1, 64'hA0000, "R6");

    // R9: VGA wins over overlapping windows
    ioEnable = 1'b1; memEnable = 1'b1; vgaEnable = 1'b1;
    issue(2'd0, 64'h3B0, "R9");
    issue(2'd0, 64'h3BC, "R9");
    issue(2'd1, 64'hB0000, "R9");
    issue(2'd1, 64'hC0000, "R9");

    // R8: verdict drops after the strobe goes away
    idle("R8");
    issue(2'd0, 64'h3DF, "R8");
    idle("R8");
    idle("R8");

    finish_run();
  end
endmodule